// File: doc/BRIEF.md
# Register-Window Trap Entry Sequencer

This block performs the state takeover that happens when a processor takes a trap or an interrupt. It samples a trap request together with an 8-bit trap type, the current program counter pair (PC and nPC), the status fields (trap enable, supervisor, previous supervisor, current window pointer) and the current trap base register. One clock later it presents the new status, the new PC pair, the updated trap base register, and two write requests that store the old PC and nPC into the window the trap enters.

The window pointer moves down by one, wrapping over a parameterised number of windows. The old PC goes to window-relative register 17 and the old nPC to register 18. Trap types 0x10 to 0x1F form the external-interrupt class and produce an acknowledge pulse carrying the level in the low four bits. A trap that arrives while traps are disabled does not enter. It drives the block into a held error state instead. The one exception is a trap of type 0x80 arriving while the shutdown feature input is set, which raises a shutdown request instead.

Top module: `trap_entry`

## Requirements
- R1: After reset, `done`, `wr_en`, `irq_ack`, `shutdown_req` and `err_state` are 0.
- R2: A trap request with `et_in`=0 that is not the shutdown case sets `err_state` one cycle later. `err_state` then stays 1 until reset. No `done` and no `wr_en` follow.
- R3: A trap request with `et_in`=0, `tt_in`=0x80 and `halt_en`=1 gives a one-cycle `shutdown_req` and no error and no entry. With `et_in`=1, type 0x80 enters normally.
- R4: While `err_state` is 1, trap requests are ignored. No `done`, `wr_en`, `irq_ack` or `shutdown_req` is produced, and `pc_out` keeps its value.
- R5: On entry, `et_out` is 0 and `cwp_out` is `cwp_in`-1, with 0 wrapping to NWIN-1.
- R6: On entry, `wr_en` pulses with `wr_win`=`cwp_out`. Port A writes the old PC to index 17 and port B writes the old nPC to index 18.
- R7: On entry, `ps_out` takes the old `s_in` and `s_out` is 1.
- R8: On entry, `tbr_out` is `tbr_in[31:12]`, then the trap type in bits 11:4, then 0 in bits 3:0.
- R9: On entry, `pc_out` equals `tbr_out` and `npc_out` equals `tbr_out`+4.
- R10: `irq_ack` pulses with the entry exactly when `tt_in[7:4]`=1, and `irq_lvl` is `tt_in[3:0]`.
- R11: Each accepted single-cycle request gives exactly one one-cycle `done`, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap taken this cycle |
| tt_in | input | 8 | Trap type |
| halt_en | input | 1 | Enables the shutdown trap type |
| pc_in | input | XLEN | Current PC |
| npc_in | input | XLEN | Current nPC |
| et_in | input | 1 | Trap enable |
| s_in | input | 1 | Supervisor bit |
| ps_in | input | 1 | Previous supervisor bit |
| cwp_in | input | CWPW | Current window pointer |
| tbr_in | input | XLEN | Current trap base register |
| done | output | 1 | Entry completed (pulse) |
| et_out | output | 1 | New trap enable |
| s_out | output | 1 | New supervisor bit |
| ps_out | output | 1 | New previous supervisor bit |
| cwp_out | output | CWPW | New window pointer |
| pc_out | output | XLEN | New PC |
| npc_out | output | XLEN | New nPC |
| tbr_out | output | XLEN | Updated trap base register |
| wr_en | output | 1 | Save-write request (pulse) |
| wr_win | output | CWPW | Window receiving the writes |
| wr_a_idx | output | 5 | Register index for the PC save |
| wr_a_data | output | XLEN | Saved PC |
| wr_b_idx | output | 5 | Register index for the nPC save |
| wr_b_data | output | XLEN | Saved nPC |
| irq_ack | output | 1 | Interrupt acknowledge (pulse) |
| irq_lvl | output | 4 | Acknowledged interrupt level |
| err_state | output | 1 | Held error state |
| shutdown_req | output | 1 | Shutdown request (pulse) |

## Verification
The bench sweeps all 256 trap types and rotates through every window pointer value, including 0. A design that failed to wrap there would point the saves at a window that does not exist. A model register file catches PC and nPC swapped between indices 17 and 18. Comparing the acknowledge against the type class catches an off-by-one class boundary, which would acknowledge 0x0F or 0x20 or miss 0x10 and 0x1F. The disabled-trap cases separate type 0x80 from 0x81 with the feature set, so a loose compare would wrongly shut down. Once in the error state, a further request must not produce entry, and a non-sticky error would let that entry through.

// File: rtl/trap_entry.sv
module trap_entry #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  parameter logic [7:0] HALT_TT = 8'h80,
  parameter logic [3:0] IRQ_CLASS = 4'h1,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic [7:0]      tt_in,
  input  logic            halt_en,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] npc_in,
  input  logic            et_in,
  input  logic            s_in,
  input  logic            ps_in,
  input  logic [CWPW-1:0] cwp_in,
  input  logic [XLEN-1:0] tbr_in,
  output logic            done,
  output logic            et_out,
  output logic            s_out,
  output logic            ps_out,
  output logic [CWPW-1:0] cwp_out,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] npc_out,
  output logic [XLEN-1:0] tbr_out,
  output logic            wr_en,
  output logic [CWPW-1:0] wr_win,
  output logic [4:0]      wr_a_idx,
  output logic [XLEN-1:0] wr_a_data,
  output logic [4:0]      wr_b_idx,
  output logic [XLEN-1:0] wr_b_data,
  output logic            irq_ack,
  output logic [3:0]      irq_lvl,
  output logic            err_state,
  output logic            shutdown_req
);
  localparam logic [CWPW-1:0] LAST_WIN = CWPW'(NWIN - 1);
  localparam logic [4:0] SAVE_PC_IDX  = 5'd17;
  localparam logic [4:0] SAVE_NPC_IDX = 5'd18;

  logic live, take, halt_hit, bad_hit, is_irq;
  logic [CWPW-1:0] cwp_dn;
  logic [XLEN-1:0] tbr_nx;

  assign live     = trap_req && !err_state;
  assign take     = live && et_in;
  assign halt_hit = live && !et_in && halt_en && (tt_in == HALT_TT);
  assign bad_hit  = live && !et_in && !halt_hit;
  assign is_irq   = (tt_in[7:4] == IRQ_CLASS);
  assign cwp_dn   = (cwp_in == '0) ? LAST_WIN : cwp_in - 1'b1;
  assign tbr_nx   = {tbr_in[XLEN-1:12], tt_in, 4'b0000};

  assign wr_a_idx = SAVE_PC_IDX;
  assign wr_b_idx = SAVE_NPC_IDX;
  assign wr_win   = cwp_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done         <= 1'b0;
      wr_en        <= 1'b0;
      irq_ack      <= 1'b0;
      irq_lvl      <= '0;
      err_state    <= 1'b0;
      shutdown_req <= 1'b0;
      et_out       <= 1'b0;
      s_out        <= 1'b1;
      ps_out       <= 1'b0;
      cwp_out      <= '0;
      pc_out       <= '0;
      npc_out      <= '0;
      tbr_out      <= '0;
      wr_a_data    <= '0;
      wr_b_data    <= '0;
    end else begin
      done         <= take;
      wr_en        <= take;
      irq_ack      <= take && is_irq;
      shutdown_req <= halt_hit;
      err_state    <= err_state || bad_hit;
      if (take) begin
        irq_lvl   <= tt_in[3:0];
        et_out    <= 1'b0;
        ps_out    <= s_in;
        s_out     <= 1'b1;
        cwp_out   <= cwp_dn;
        tbr_out   <= tbr_nx;
        pc_out    <= tbr_nx;
        npc_out   <= tbr_nx + XLEN'(4);
        wr_a_data <= pc_in;
        wr_b_data <= npc_in;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> !done && !wr_en && !irq_ack && !err_state && !shutdown_req);

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_state |=> err_state);

  p_no_entry_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !et_in |=> !done && !wr_en);

  p_halt_only_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> !done && $past(tt_in) == HALT_TT && !$past(et_in));

  p_err_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_state |=> !done && !wr_en && !irq_ack && !shutdown_req);

  p_cwp_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(cwp_in) == '0 |-> cwp_out == LAST_WIN);

  p_cwp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(cwp_in) != '0 |-> cwp_out + 1'b1 == $past(cwp_in) && !et_out);

  p_save_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_a_data == $past(pc_in) && wr_b_data == $past(npc_in) && wr_win == cwp_out);

  p_super_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> s_out && ps_out == $past(s_in));

  p_pc_from_tbr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pc_out == tbr_out && npc_out - pc_out == XLEN'(4) && tbr_out[3:0] == 4'b0);

  p_ack_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> done && tbr_out[11:8] == IRQ_CLASS && irq_lvl == tbr_out[7:4]);

  p_done_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(trap_req) && $past(et_in));
endmodule

// File: tb/test_trap_entry.sv
module test_trap_entry;
  localparam int PERIOD = 10;
  localparam int NW = 8;
  localparam int XW = 32;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_req = 1'b0, halt_en = 1'b0, et_in = 1'b0, s_in = 1'b0, ps_in = 1'b0;
  logic [7:0] tt_in = '0;
  logic [XW-1:0] pc_in = '0, npc_in = '0, tbr_in = '0;
  logic [CW-1:0] cwp_in = '0;
  logic done, et_out, s_out, ps_out, wr_en, irq_ack, err_state, shutdown_req;
  logic [CW-1:0] cwp_out, wr_win;
  logic [XW-1:0] pc_out, npc_out, tbr_out, wr_a_data, wr_b_data;
  logic [4:0] wr_a_idx, wr_b_idx;
  logic [3:0] irq_lvl;

  int n_run = 0, n_fail = 0;
  logic [XW-1:0] rf [NW][32];

  always #(PERIOD/2) clk = ~clk;

  trap_entry #(.NWIN(NW), .XLEN(XW)) i_trap_entry (
    .clk, .rst_n, .trap_req, .tt_in, .halt_en, .pc_in, .npc_in, .et_in, .s_in,
    .ps_in, .cwp_in, .tbr_in, .done, .et_out, .s_out, .ps_out, .cwp_out, .pc_out,
    .npc_out, .tbr_out, .wr_en, .wr_win, .wr_a_idx, .wr_a_data, .wr_b_idx,
    .wr_b_data, .irq_ack, .irq_lvl, .err_state, .shutdown_req);

  always @(posedge clk) if (wr_en) begin
    rf[wr_win][wr_a_idx] <= wr_a_data;
    rf[wr_win][wr_b_idx] <= wr_b_data;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] tt, input logic et, input logic hen,
                       input logic s, input logic [CW-1:0] cwp, input logic [XW-1:0] tbr);
    tt_in = tt; et_in = et; halt_en = hen; s_in = s; ps_in = ~s; cwp_in = cwp;
    tbr_in = tbr;
    pc_in = {tt, ~tt, 16'h4000} + XW'(cwp);
    npc_in = pc_in + 32'd4;
    trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 wr_en", wr_en, 0);
    check("R1 irq_ack", irq_ack, 0);
    check("R1 err_state", err_state, 0);
    check("R1 shutdown_req", shutdown_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < 256; t++) begin
      logic [CW-1:0] cw;
      logic [CW-1:0] ncw;
      logic [XW-1:0] tb, etbr, opc, onpc;
      cw = CW'(t % NW);
      ncw = (cw == 0) ? CW'(NW - 1) : cw - 1'b1;
      tb = 32'hA5A5_5000 ^ (XW'(t) << 12);
      etbr = {tb[31:12], 8'(t), 4'h0};
      drive(8'(t), 1'b1, t[1], t[0], cw, tb);
      opc = pc_in; onpc = npc_in;
      check("R11 done", done, 1);
      check("R3 no shutdown when enabled", shutdown_req, 0);
      check("R2 no error when enabled", err_state, 0);
      check("R5 et_out", et_out, 0);
      check("R5 cwp_out", cwp_out, ncw);
      check("R6 wr_en", wr_en, 1);
      check("R6 wr_win", wr_win, ncw);
      check("R6 pc index", wr_a_idx, 17);
      check("R6 npc index", wr_b_idx, 18);
      check("R7 s_out", s_out, 1);
      check("R7 ps_out", ps_out, t[0]);
      check("R8 tbr_out", tbr_out, etbr);
      check("R9 pc_out", pc_out, etbr);
      check("R9 npc_out", npc_out, etbr + 32'd4);
      check("R10 irq_ack", irq_ack, (t >= 16 && t < 32) ? 1 : 0);
      if (t >= 16 && t < 32) check("R10 irq_lvl", irq_lvl, t % 16);
      @(negedge clk);
      check("R11 done single", done, 0);
      check("R10 ack single", irq_ack, 0);
      check("R6 rf saved pc", rf[ncw][17], opc);
      check("R6 rf saved npc", rf[ncw][18], onpc);
    end

    drive(8'h80, 1'b0, 1'b1, 1'b0, 3'd2, 32'h1234_5000);
    check("R3 shutdown", shutdown_req, 1);
    check("R3 no error", err_state, 0);
    check("R3 no done", done, 0);
    check("R3 no write", wr_en, 0);
    @(negedge clk);
    check("R3 shutdown single", shutdown_req, 0);

    drive(8'h81, 1'b0, 1'b1, 1'b0, 3'd2, 32'h1234_5000);
    check("R2 error set", err_state, 1);
    check("R2 no shutdown", shutdown_req, 0);
    check("R2 no done", done, 0);
    check("R2 no write", wr_en, 0);
    @(negedge clk);
    check("R2 error held", err_state, 1);

    begin
      logic [XW-1:0] held;
      held = pc_out;
      drive(8'h15, 1'b1, 1'b0, 1'b1, 3'd4, 32'h0000_0000);
      check("R4 no done", done, 0);
      check("R4 no write", wr_en, 0);
      check("R4 no ack", irq_ack, 0);
      check("R4 pc kept", pc_out, held);
      drive(8'h80, 1'b0, 1'b1, 1'b0, 3'd4, 32'h0000_0000);
      check("R4 no shutdown", shutdown_req, 0);
      check("R2 error still held", err_state, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule